// File: doc/BRIEF.md
# Bidirectional Threshold Step Divider

This block divides a single-phase step stream by a configurable integer while keeping track of direction. Each incoming step strobe comes with a direction bit, as produced by a times-four quadrature decoder. The block keeps a signed up/down accumulator of net motion. It emits one output step, together with an output direction bit, only when the net motion reaches a full ratio's worth of steps in one sense.

Back-and-forth dither that stays inside the band between the negative and the positive threshold produces no output step. It also never moves the output direction. A stationary axis that vibrates therefore reports nothing downstream. The divide ratio takes a default value at reset and can be rewritten at run time through a one-cycle write strobe. A write also restarts the accumulator from zero.

Top module: `bidir_step_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `step_out` is 0, `dir_out` is 1 and the accumulator is zero.
- R2: An accepted step with `dir_in`=1 adds one to the accumulator. When the sum reaches +N, one output step is produced with `dir_out`=1.
- R3: An accepted step with `dir_in`=0 subtracts one from the accumulator. When the difference reaches -N, one output step is produced with `dir_out`=0.
- R4: An accepted step that leaves the accumulator strictly between -N and +N produces no output step and leaves `dir_out` unchanged, however often `dir_in` toggles.
- R5: A threshold hit returns the accumulator to zero, so the next output step needs another N net steps. The accumulator never leaves the open band (-N, +N).
- R6: `step_out` is high for exactly the clock cycle after the edge at which the causing step was accepted. It is never high unless a step was accepted at the previous edge.
- R7: When `ratio_we` is 1, `ratio_wdata` becomes the new ratio and the accumulator is cleared. A step presented in that same cycle is discarded, and no output step follows that cycle.
- R8: With a ratio of 1, every accepted step appears one cycle later on `step_out`, with `dir_out` equal to that step's `dir_in`. A written ratio of 0 behaves as 1.
- R9: After reset the ratio is the parameter `RESET_RATIO`.
- R10: `dir_out` changes only in a cycle in which `step_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_we | input | 1 | Ratio write strobe (one cycle) |
| ratio_wdata | input | RATIO_W | New divide ratio; 0 is taken as 1 |
| step_in | input | 1 | Input step strobe, one per clock when high |
| dir_in | input | 1 | Direction of the step: 1 forward, 0 reverse |
| step_out | output | 1 | Divided output step strobe |
| dir_out | output | 1 | Direction of the most recent output step |

## Verification
The bench builds the block with `RATIO_W`=4 and `RESET_RATIO`=3. The narrow ratio field lets random run-time writes reach the zero ratio, the pass-through ratio of 1 and the widest ratio of 15, all within a short run. The default ratio of 3 makes each threshold reachable with a few directed steps. Directed sequences cover dither inside the band, a write colliding with a step, and back-to-back steps at ratio 1. A long random walk with drifting direction bias then exercises both thresholds against the bench's integer model.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Per-cycle decision taken by the accumulator.
  typedef enum logic [2:0] {
    ACT_HOLD     = 3'd0,
    ACT_MOVE     = 3'd1,
    ACT_FIRE_POS = 3'd2,
    ACT_FIRE_NEG = 3'd3,
    ACT_CLEAR    = 3'd4
  } sdiv_act_e;

  localparam logic DIR_FWD = 1'b1;
  localparam logic DIR_REV = 1'b0;

endpackage

// File: rtl/sdiv_ratio_reg.sv
module sdiv_ratio_reg #(
  parameter int RATIO_W     = 8,
  parameter int RESET_RATIO = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RATIO_W-1:0] wdata,
  output logic [RATIO_W-1:0] ratio_eff,
  output logic               load_evt
);

  localparam logic [RATIO_W-1:0] RST_VAL = RATIO_W'(RESET_RATIO);

  logic [RATIO_W-1:0] ratio_q;

  // A zero ratio is meaningless for a divider: run it as divide-by-one.
  function automatic logic [RATIO_W-1:0] sanitize(input logic [RATIO_W-1:0] r);
    if (r == '0) return {{(RATIO_W-1){1'b0}}, 1'b1};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ratio_q <= RST_VAL;
    else if (we) ratio_q <= wdata;
  end

  assign ratio_eff = sanitize(ratio_q);
  assign load_evt  = we;

endmodule

// File: rtl/sdiv_accum.sv
module sdiv_accum
  import sdiv_pkg::*;
#(
  parameter int RATIO_W = 8,
  localparam int CNT_W  = RATIO_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic                    dir,
  input  logic [RATIO_W-1:0]      ratio_eff,
  output logic signed [CNT_W-1:0] count,
  output sdiv_act_e               action
);

  logic signed [CNT_W-1:0] nxt;
  logic signed [CNT_W-1:0] lim;

  function automatic logic signed [CNT_W-1:0] widen(input logic [RATIO_W-1:0] r);
    return signed'({2'b00, r});
  endfunction

  function automatic logic signed [CNT_W-1:0] delta(input logic d);
    if (d == DIR_FWD) return signed'({{(CNT_W-1){1'b0}}, 1'b1});
    return signed'({CNT_W{1'b1}});
  endfunction

  function automatic sdiv_act_e classify(
    input logic                    clr,
    input logic                    stp,
    input logic signed [CNT_W-1:0] cand,
    input logic signed [CNT_W-1:0] thr
  );
    if (clr)          return ACT_CLEAR;
    if (!stp)         return ACT_HOLD;
    if (cand == thr)  return ACT_FIRE_POS;
    if (cand == -thr) return ACT_FIRE_NEG;
    return ACT_MOVE;
  endfunction

  assign lim    = widen(ratio_eff);
  assign nxt    = count + delta(dir);
  assign action = classify(clear, step, nxt, lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case (action)
        ACT_MOVE:                            count <= nxt;
        ACT_CLEAR, ACT_FIRE_POS, ACT_FIRE_NEG: count <= '0;
        default:                             count <= count;
      endcase
    end
  end

endmodule

// File: rtl/sdiv_out_stage.sv
module sdiv_out_stage
  import sdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sdiv_act_e action,
  output logic      step_q,
  output logic      dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      dir_q  <= DIR_FWD;
    end else begin
      step_q <= (action == ACT_FIRE_POS) || (action == ACT_FIRE_NEG);
      if (action == ACT_FIRE_POS)      dir_q <= DIR_FWD;
      else if (action == ACT_FIRE_NEG) dir_q <= DIR_REV;
    end
  end

endmodule

// File: rtl/bidir_step_divider.sv
module bidir_step_divider
  import sdiv_pkg::*;
#(
  parameter int RATIO_W     = 8,
  parameter int RESET_RATIO = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_we,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               step_in,
  input  logic               dir_in,
  output logic               step_out,
  output logic               dir_out
);

  localparam int CNT_W = RATIO_W + 2;

  logic [RATIO_W-1:0]      eff_n;
  logic                    load_evt;
  logic signed [CNT_W-1:0] acc_count;
  sdiv_act_e               acc_action;
  logic                    fire_pos;
  logic                    fire_neg;

  sdiv_ratio_reg #(
    .RATIO_W    (RATIO_W),
    .RESET_RATIO(RESET_RATIO)
  ) u_ratio (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ratio_we),
    .wdata    (ratio_wdata),
    .ratio_eff(eff_n),
    .load_evt (load_evt)
  );

  sdiv_accum #(
    .RATIO_W(RATIO_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load_evt),
    .step     (step_in),
    .dir      (dir_in),
    .ratio_eff(eff_n),
    .count    (acc_count),
    .action   (acc_action)
  );

  // Named threshold events, brought out for the checker.
  assign fire_pos = (acc_action == ACT_FIRE_POS);
  assign fire_neg = (acc_action == ACT_FIRE_NEG);

  sdiv_out_stage u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .action(acc_action),
    .step_q(step_out),
    .dir_q (dir_out)
  );

endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int RATIO_W = 8,
  localparam int CNT_W  = RATIO_W + 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step_in,
  input logic                    dir_in,
  input logic                    ratio_we,
  input logic                    step_out,
  input logic                    dir_out,
  input logic [RATIO_W-1:0]      eff_n,
  input logic signed [CNT_W-1:0] acc_count,
  input logic                    fire_pos,
  input logic                    fire_neg
);

  logic signed [CNT_W-1:0] band;
  logic                    accepted;

  assign band     = signed'({2'b00, eff_n});
  assign accepted = step_in && !ratio_we;

  // R2: a positive threshold hit yields a forward output step
  a_r2_fire_pos: assert property (@(posedge clk) disable iff (!rst_n)
    fire_pos |=> (step_out && dir_out));

  // R3: a negative threshold hit yields a reverse output step
  a_r3_fire_neg: assert property (@(posedge clk) disable iff (!rst_n)
    fire_neg |=> (step_out && !dir_out));

  // R4: accepted step inside the band is silent
  a_r4_quiet_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !fire_pos && !fire_neg) |=> !step_out);

  // R5: accumulator stays inside the open band
  a_r5_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_count < band) && (acc_count > -band));

  // R6: output step only after an accepted input step
  a_r6_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |-> $past(accepted));

  // R7: a ratio write clears and stays silent
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_we |=> (!step_out && acc_count == '0));

  // R8: divide-by-one passes each step through
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_n == RATIO_W'(1) && accepted) |=> (step_out && dir_out == $past(dir_in)));

  // R10: direction moves only with an output step
  a_r10_dir_with_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_out) |-> step_out);

endmodule

bind bidir_step_divider sdiv_checker #(.RATIO_W(RATIO_W)) u_sdiv_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step_in  (step_in),
  .dir_in   (dir_in),
  .ratio_we (ratio_we),
  .step_out (step_out),
  .dir_out  (dir_out),
  .eff_n    (eff_n),
  .acc_count(acc_count),
  .fire_pos (fire_pos),
  .fire_neg (fire_neg)
);

// File: tb/bidir_step_divider_bench.sv
module bidir_step_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RW         = 4;
  localparam int RST_RATIO  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ratio_we = 1'b0;
  logic [RW-1:0] ratio_wdata = '0;
  logic          step_in = 1'b0;
  logic          dir_in = 1'b0;
  logic          step_out;
  logic          dir_out;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit finished = 0;

  // Reference model state (integers, behavioural)
  int m_n;
  int m_acc;
  bit m_step;
  bit m_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_step_divider #(.RATIO_W(RW), .RESET_RATIO(RST_RATIO)) u_bidir_step_divider (
    .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_wdata(ratio_wdata),
    .step_in(step_in), .dir_in(dir_in), .step_out(step_out), .dir_out(dir_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Model: reacts to the inputs at each rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = RST_RATIO; m_acc = 0; m_step = 0; m_dir = 1;
    end else begin
      int lim;
      m_step = 0;
      if (ratio_we) begin
        m_n = int'(ratio_wdata);
        m_acc = 0;
      end else if (step_in) begin
        lim = (m_n == 0) ? 1 : m_n;
        m_acc = m_acc + (dir_in ? 1 : -1);
        if (m_acc >= lim)       begin m_step = 1; m_dir = 1; m_acc = 0; end
        else if (m_acc <= -lim) begin m_step = 1; m_dir = 0; m_acc = 0; end
      end
    end
  end

  // Per-cycle comparison and pulse counting, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(step_out == m_step, "R6/R2/R3/R4 step_out vs model", step_out, m_step);
      check(dir_out == m_dir, "R10/R2/R3 dir_out vs model", dir_out, m_dir);
      if (step_out) pulses++;
    end
  end

  task automatic steps(input int n, input bit d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_in = 1'b1; dir_in = d;
      @(negedge clk); step_in = 1'b0;
    end
  endtask

  task automatic burst(input int n, input bit d);
    @(negedge clk);
    step_in = 1'b1; dir_in = d;
    repeat (n) @(negedge clk);
    step_in = 1'b0;
  endtask

  task automatic wr_ratio(input int v, input bit st, input bit d);
    @(negedge clk);
    ratio_we = 1'b1; ratio_wdata = RW'(v); step_in = st; dir_in = d;
    @(negedge clk);
    ratio_we = 1'b0; step_in = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(step_out == 1'b0, "R1 step_out in reset", step_out, 0);
    check(dir_out == 1'b1, "R1 dir_out in reset", dir_out, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(step_out == 1'b0 && dir_out == 1'b1, "R1 outputs after reset", {step_out, dir_out}, 1);

    steps(2, 1); settle();
    check(pulses == 0, "R9 default ratio 3: two steps silent", pulses, 0);
    steps(1, 1); settle();
    check(pulses == 1, "R2 third forward step fires", pulses, 1);
    check(dir_out == 1'b1, "R2 forward direction", dir_out, 1);

    for (int k = 0; k < 8; k++) begin steps(1, 1); steps(1, 0); end
    settle();
    check(pulses == 1, "R4 dither gives no output", pulses, 1);
    check(dir_out == 1'b1, "R4 dither keeps direction", dir_out, 1);

    steps(3, 0); settle();
    check(pulses == 2, "R3 three reverse steps fire", pulses, 2);
    check(dir_out == 1'b0, "R3 reverse direction", dir_out, 0);

    steps(2, 1); settle();
    check(pulses == 2 && dir_out == 1'b0, "R4 partial forward motion holds direction", pulses, 2);
    steps(1, 1); settle();
    check(pulses == 3 && dir_out == 1'b1, "R2 net forward reaches threshold", pulses, 3);
    steps(2, 1); settle();
    check(pulses == 3, "R5 count restarted at zero", pulses, 3);
    steps(1, 1); settle();
    check(pulses == 4, "R5 another full ratio fires", pulses, 4);

    steps(2, 1);
    wr_ratio(3, 1, 1); settle();
    check(pulses == 4, "R7 write with step gives no output", pulses, 4);
    steps(2, 1); settle();
    check(pulses == 4, "R7 accumulator cleared, step dropped", pulses, 4);
    steps(1, 1); settle();
    check(pulses == 5, "R7 full ratio after write fires", pulses, 5);

    wr_ratio(1, 0, 0);
    burst(4, 0); settle();
    check(pulses == 9, "R8 ratio 1 passes each step", pulses, 9);
    check(dir_out == 1'b0, "R8 ratio 1 copies direction", dir_out, 0);
    wr_ratio(0, 0, 0);
    steps(1, 1); settle();
    check(pulses == 10 && dir_out == 1'b1, "R8 ratio 0 acts as 1", pulses, 10);

    wr_ratio(5, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int bias;
      @(negedge clk);
      bias = ((i / 250) % 2 == 0) ? 80 : 20;
      ratio_we = ($urandom_range(0, 199) == 0);
      ratio_wdata = RW'($urandom_range(0, 15));
      step_in = ($urandom_range(0, 99) < 70);
      dir_in = ($urandom_range(0, 99) < bias);
    end
    @(negedge clk);
    ratio_we = 1'b0; step_in = 1'b0;
    settle();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule